// File: doc/BRIEF.md
# Programmable Delay Trigger Generator

This block turns a single start event into a timed burst of short strobes. A start event is either a rising edge on an external pin, brought into the clock domain by a synchroniser, or a one-cycle software strobe; a select input picks which of the two is live. Each event clears a free-running counter to zero and starts it. Every channel holds several delay slots. A slot emits a one-cycle strobe when the counter passes its programmed delay, and the channel output is the OR of that channel's strobes. A converter or other sampled unit can use these strobes to start work at fixed offsets from a common event.

The counter either halts at a programmed modulus and waits for the next event (single-shot), or wraps to zero at the modulus and repeats the strobe pattern with no further event (repeating). Any slot can skip its delay and fire in the cycle right after the event or wrap. A debug-halt input freezes the count while it is high. Dropping the enable stops everything and forces all outputs low.

Top module: `dly_trig_gen`

## Requirements
- R1: While `en` is 0 every `pre_trig` and `trig_out` bit is 0, the counter is held at zero and stopped, and start events are ignored; raising `en` again without a new event produces no strobes.
- R2: While `dbg_halt` is 1 the count holds its value; each halted cycle delays every later strobe by one cycle.
- R3: `src_sel` = 0 selects the external pin, `src_sel` = 1 the software strobe. A rising edge on `ext_trig` passes a two-stage synchroniser and acts at the third clock edge after the pin is sampled high. `sw_trig` acts at the edge where it is high. Activity on the unselected source has no effect.
- R4: In single-shot mode (`cont_mode` = 0) a slot with delay d and d <= modulus is high for exactly the cycle that begins d+1 edges after the event edge. The counter then stops at the modulus, and a slot with d > modulus never fires.
- R5: Each strobe lasts one cycle, and a slot fires at most once per count period.
- R6: `trig_out[c]` is the OR of slots c*N_PRE to c*N_PRE+N_PRE-1 of `pre_trig`; slot i takes its delay from `delay[i*CNT_W +: CNT_W]`.
- R7: In repeating mode (`cont_mode` = 1) the counter wraps from the modulus to zero, so every strobe repeats with a period of modulus+1 cycles after one event.
- R8: A slot with its `pre_byp` bit set ignores its delay. It is high in the cycle right after the event edge and, in repeating mode, in the cycle right after every wrap.
- R9: A slot whose `pre_en` bit is 0 never fires.
- R10: An event that arrives while the count is running restarts the count from zero, and pending strobes fire relative to the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| ext_trig | input | 1 | External start pin (asynchronous) |
| sw_trig | input | 1 | Software start strobe, one cycle |
| src_sel | input | 1 | Start source: 0 external, 1 software |
| cont_mode | input | 1 | 0 single-shot, 1 repeating |
| dbg_halt | input | 1 | Freeze the count while high |
| modulus | input | CNT_W | Last count value of a period |
| delay | input | N_CH*N_PRE*CNT_W | Packed per-slot delay values |
| pre_en | input | N_CH*N_PRE | Per-slot enable |
| pre_byp | input | N_CH*N_PRE | Per-slot delay bypass |
| pre_trig | output | N_CH*N_PRE | Per-slot one-cycle strobes |
| trig_out | output | N_CH | Per-channel OR of its slot strobes |

## Verification
The bench aims at the places where counting goes wrong by one. It covers a delay equal to the modulus (an off-by-one stop drops or doubles that strobe), a delay past the modulus (a missing bound fires it after a wrap that never happens), and a modulus of zero in repeating mode (a design that clears a slot's fired state late misses every other cycle). It holds debug halt across four cycles, and a counter that keeps running shows the strobe four cycles early. It also sends a second start event mid-count, sends events from the unselected source, and drops the enable mid-run. A design that does not restart, filters sources wrongly, or lets the counter run on while disabled then shows strobes in the wrong cycles or strobes that should not appear.

// File: rtl/dly_trig_pkg.sv
package dly_trig_pkg;

   typedef enum logic {
      SRC_PIN = 1'b0,
      SRC_SW  = 1'b1
   } start_src_e;

   typedef enum logic {
      MODE_SINGLE = 1'b0,
      MODE_REPEAT = 1'b1
   } count_mode_e;

endpackage

// File: rtl/dly_trig_start.sv
module dly_trig_start
   import dly_trig_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ext_trig,
   input  logic sw_trig,
   input  logic src_sel,
   output logic start_evt
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   pin_rise;
   start_src_e             src;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dly_trig_start: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_trig};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign pin_rise  = sync_q[SYNC_STAGES-1] & ~last_q;
   assign src       = start_src_e'(src_sel);
   assign start_evt = en & ((src == SRC_SW) ? sw_trig : pin_rise);

endmodule

// File: rtl/dly_trig_count.sv
module dly_trig_count
   import dly_trig_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             dbg_halt,
   input  logic             cont_mode,
   input  logic [CNT_W-1:0] modulus,
   input  logic             start_evt,
   output logic [CNT_W-1:0] cnt,
   output logic             running,
   output logic             wrap
);

   logic        at_end;
   logic        advance;
   count_mode_e mode;

   assign mode    = count_mode_e'(cont_mode);
   assign at_end  = (cnt == modulus);
   assign advance = en & running & ~dbg_halt & ~start_evt;
   assign wrap    = advance & at_end & (mode == MODE_REPEAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (!en) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (start_evt) begin
         cnt     <= '0;
         running <= 1'b1;
      end else if (advance) begin
         if (at_end) begin
            if (mode == MODE_REPEAT) begin
               cnt <= '0;
            end else begin
               running <= 1'b0;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dly_trig_slot.sv
module dly_trig_slot #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             slot_en,
   input  logic             slot_byp,
   input  logic [CNT_W-1:0] dly,
   input  logic [CNT_W-1:0] cnt,
   input  logic             running,
   input  logic             restart,
   output logic             pulse
);

   logic fired_q;
   logic hit;

   assign hit = running & ~slot_byp & ~fired_q & (cnt == dly);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired_q <= 1'b0;
         pulse   <= 1'b0;
      end else if (!en) begin
         fired_q <= 1'b0;
         pulse   <= 1'b0;
      end else begin
         pulse   <= slot_en & (slot_byp ? restart : hit);
         fired_q <= restart ? 1'b0 : (fired_q | hit);
      end
   end

endmodule

// File: rtl/dly_trig_gen.sv
module dly_trig_gen #(
   parameter int N_CH        = 2,
   parameter int N_PRE       = 4,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int NPT        = N_CH * N_PRE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 ext_trig,
   input  logic                 sw_trig,
   input  logic                 src_sel,
   input  logic                 cont_mode,
   input  logic                 dbg_halt,
   input  logic [CNT_W-1:0]     modulus,
   input  logic [NPT*CNT_W-1:0] delay,
   input  logic [NPT-1:0]       pre_en,
   input  logic [NPT-1:0]       pre_byp,
   output logic [NPT-1:0]       pre_trig,
   output logic [N_CH-1:0]      trig_out
);

   generate
      if (N_CH < 1 || N_PRE < 1) begin : g_bad_shape
         $error("dly_trig_gen: N_CH and N_PRE must be positive");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("dly_trig_gen: CNT_W must lie in 2..32");
      end
   endgenerate

   logic             start_evt;
   logic [CNT_W-1:0] cnt_q;
   logic             running_q;
   logic             wrap;
   logic             restart;
   logic [NPT-1:0]   pulse_q;

   dly_trig_start #(.SYNC_STAGES(SYNC_STAGES)) u_start (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .ext_trig  (ext_trig),
      .sw_trig   (sw_trig),
      .src_sel   (src_sel),
      .start_evt (start_evt)
   );

   dly_trig_count #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .dbg_halt  (dbg_halt),
      .cont_mode (cont_mode),
      .modulus   (modulus),
      .start_evt (start_evt),
      .cnt       (cnt_q),
      .running   (running_q),
      .wrap      (wrap)
   );

   assign restart = start_evt | wrap;

   generate
      for (genvar gi = 0; gi < NPT; gi++) begin : g_slot
         dly_trig_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en),
            .slot_en  (pre_en[gi]),
            .slot_byp (pre_byp[gi]),
            .dly      (delay[gi*CNT_W +: CNT_W]),
            .cnt      (cnt_q),
            .running  (running_q),
            .restart  (restart),
            .pulse    (pulse_q[gi])
         );
         assign pre_trig[gi] = pulse_q[gi] & en;
      end
      for (genvar gc = 0; gc < N_CH; gc++) begin : g_chan
         assign trig_out[gc] = |pre_trig[gc*N_PRE +: N_PRE];
      end
   endgenerate

endmodule

// File: rtl/dly_trig_chk.sv
module dly_trig_chk #(
   parameter int CNT_W = 16,
   parameter int NPT   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             dbg_halt,
   input logic             cont_mode,
   input logic [CNT_W-1:0] modulus,
   input logic             start_evt,
   input logic             restart,
   input logic [CNT_W-1:0] cnt_q,
   input logic             running_q,
   input logic [NPT-1:0]   pulse_q,
   input logic [NPT-1:0]   pre_en,
   input logic [NPT-1:0]   pre_byp
);

   assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0) && !running_q);

   assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      en && running_q && dbg_halt && !start_evt |=> $stable(cnt_q) && running_q);

   assert_single_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en && running_q && !cont_mode && !dbg_halt && !start_evt && (cnt_q == modulus)
      |=> !running_q && (cnt_q == $past(cnt_q)));

   assert_repeat_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      en && running_q && cont_mode && !dbg_halt && !start_evt && (cnt_q == modulus)
      |=> running_q && (cnt_q == '0));

   assert_restart_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> running_q && (cnt_q == '0));

   generate
      for (genvar gi = 0; gi < NPT; gi++) begin : g_slot_chk
         assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_q[gi] && !pre_byp[gi] && !$past(restart) |=> !pulse_q[gi]);

         assert_bypass_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
            en && restart && pre_en[gi] && pre_byp[gi] |=> pulse_q[gi]);

         assert_slot_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !pre_en[gi] |=> !pulse_q[gi]);
      end
   endgenerate

endmodule

bind dly_trig_gen dly_trig_chk #(.CNT_W(CNT_W), .NPT(NPT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .dbg_halt  (dbg_halt),
   .cont_mode (cont_mode),
   .modulus   (modulus),
   .start_evt (start_evt),
   .restart   (restart),
   .cnt_q     (cnt_q),
   .running_q (running_q),
   .pulse_q   (pulse_q),
   .pre_en    (pre_en),
   .pre_byp   (pre_byp)
);

// File: tb/dly_trig_gen_bench.sv
`timescale 1ns/1ps
module dly_trig_gen_bench;

   localparam int N_CH  = 2;
   localparam int N_PRE = 4;
   localparam int CNT_W = 16;
   localparam int NPT   = N_CH * N_PRE;
   localparam int WIN   = 40;

   typedef struct packed {
      logic       cont;
      logic       src;
      logic [7:0] modv;
      logic [7:0] base;
      logic [7:0] step;
      logic [7:0] byp;
      logic [7:0] pen;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b0, 1'b1, 8'd20, 8'd0, 8'd3, 8'h00, 8'hFF},
      '{1'b0, 1'b0, 8'd30, 8'd2, 8'd2, 8'h05, 8'hFF},
      '{1'b1, 1'b1, 8'd9,  8'd1, 8'd1, 8'h80, 8'hFF},
      '{1'b1, 1'b0, 8'd4,  8'd0, 8'd2, 8'h10, 8'h3C},
      '{1'b0, 1'b1, 8'd5,  8'd5, 8'd0, 8'h00, 8'h81},
      '{1'b1, 1'b1, 8'd0,  8'd0, 8'd0, 8'h02, 8'h03}
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 en = 1'b0;
   logic                 ext_trig = 1'b0;
   logic                 sw_trig = 1'b0;
   logic                 src_sel = 1'b1;
   logic                 cont_mode = 1'b0;
   logic                 dbg_halt = 1'b0;
   logic [CNT_W-1:0]     modulus = '0;
   logic [NPT*CNT_W-1:0] delay = '0;
   logic [NPT-1:0]       pre_en = '0;
   logic [NPT-1:0]       pre_byp = '0;
   logic [NPT-1:0]       pre_trig;
   logic [N_CH-1:0]      trig_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   dly_trig_gen #(.N_CH(N_CH), .N_PRE(N_PRE), .CNT_W(CNT_W)) u_dly_trig_gen (
      .clk(clk), .rst_n(rst_n), .en(en), .ext_trig(ext_trig), .sw_trig(sw_trig),
      .src_sel(src_sel), .cont_mode(cont_mode), .dbg_halt(dbg_halt),
      .modulus(modulus), .delay(delay), .pre_en(pre_en), .pre_byp(pre_byp),
      .pre_trig(pre_trig), .trig_out(trig_out)
   );

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   // Expected strobe of one slot at sample k (k = 1 is the cycle after the event edge).
   function automatic logic exp_bit(int k, int d, logic byp, logic pe, int m, logic cont);
      if (!pe) return 1'b0;
      if (byp) begin
         if (cont) return ((k - 1) % (m + 1)) == 0;
         return k == 1;
      end
      if (d > m) return 1'b0;
      if (cont) return (k - 2 >= d) && (((k - 2 - d) % (m + 1)) == 0);
      return k == d + 2;
   endfunction

   function automatic logic [N_CH+NPT-1:0] with_or(logic [NPT-1:0] p);
      logic [N_CH-1:0] t;
      for (int c = 0; c < N_CH; c++) t[c] = |p[c*N_PRE +: N_PRE];
      return {t, p};
   endfunction

   task automatic check(string tag, logic [N_CH+NPT-1:0] act, logic [N_CH+NPT-1:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, expv);
      end
   endtask

   task automatic set_cfg(logic cont, logic src, int m, int base, int step,
                          logic [NPT-1:0] byp, logic [NPT-1:0] pen);
      @(negedge clk);
      en = 1'b0;
      repeat (2) @(negedge clk);
      cont_mode = cont;
      src_sel   = src;
      modulus   = CNT_W'(m);
      for (int i = 0; i < NPT; i++) delay[i*CNT_W +: CNT_W] = CNT_W'(base + i * step);
      pre_byp = byp;
      pre_en  = pen;
      en      = 1'b1;
   endtask

   // Ends at the negedge of sample k = 1.
   task automatic fire(logic use_pin);
      if (use_pin) begin
         @(negedge clk) ext_trig = 1'b1;
         repeat (3) @(negedge clk);
         ext_trig = 1'b0;
      end else begin
         @(negedge clk) sw_trig = 1'b1;
         @(negedge clk) sw_trig = 1'b0;
      end
   endtask

   initial begin
      logic [NPT-1:0] e;
      repeat (3) @(negedge clk);
      // Reset state
      check("R1 reset", {trig_out, pre_trig}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {trig_out, pre_trig}, '0);

      // Table walk: R3 R4 R5 R6 R7 R8 R9
      for (int v = 0; v < 6; v++) begin
         set_cfg(VECS[v].cont, VECS[v].src, VECS[v].modv, VECS[v].base, VECS[v].step,
                 VECS[v].byp, VECS[v].pen);
         fire(!VECS[v].src);
         for (int k = 1; k <= WIN; k++) begin
            for (int i = 0; i < NPT; i++)
               e[i] = exp_bit(k, VECS[v].base + i * VECS[v].step, VECS[v].byp[i],
                              VECS[v].pen[i], VECS[v].modv, VECS[v].cont);
            check($sformatf("R4 R5 R6 R7 R8 R9 vector %0d k=%0d", v, k),
                  {trig_out, pre_trig}, with_or(e));
            @(negedge clk);
         end
      end

      // R1: event while disabled does nothing
      set_cfg(1'b0, 1'b1, 20, 0, 1, 8'h01, 8'hFF);
      en = 1'b0;
      fire(1'b0);
      for (int k = 1; k <= 12; k++) begin
         check("R1 disabled event", {trig_out, pre_trig}, '0);
         @(negedge clk);
      end
      // R1: enable dropped mid-run, counter must not resume
      en = 1'b1;
      fire(1'b0);
      check("R1 bypass before drop", {trig_out, pre_trig}, with_or(8'h01));
      @(negedge clk);
      en = 1'b0;
      check("R1 dropped", {trig_out, pre_trig}, '0);
      @(negedge clk);
      en = 1'b1;
      for (int k = 1; k <= 25; k++) begin
         check("R1 re-enabled without event", {trig_out, pre_trig}, '0);
         @(negedge clk);
      end

      // R3: unselected software strobe ignored
      set_cfg(1'b0, 1'b0, 20, 3, 1, 8'h01, 8'hFF);
      fire(1'b0);
      for (int k = 1; k <= 15; k++) begin
         check("R3 sw strobe with pin selected", {trig_out, pre_trig}, '0);
         @(negedge clk);
      end
      // R3: unselected pin edge ignored
      set_cfg(1'b0, 1'b1, 20, 3, 1, 8'h01, 8'hFF);
      fire(1'b1);
      for (int k = 1; k <= 15; k++) begin
         check("R3 pin edge with sw selected", {trig_out, pre_trig}, '0);
         @(negedge clk);
      end

      // R2: four halted cycles shift a delay-5 strobe from k=7 to k=11
      set_cfg(1'b0, 1'b1, 20, 5, 0, 8'h00, 8'h01);
      fire(1'b0);
      for (int k = 1; k <= 16; k++) begin
         e = '0;
         e[0] = (k == 11);
         check($sformatf("R2 halt k=%0d", k), {trig_out, pre_trig}, with_or(e));
         dbg_halt = (k >= 2 && k < 6);
         @(negedge clk);
      end
      dbg_halt = 1'b0;

      // R10: second event at edge k=4 moves a delay-6 strobe from k=8 to k=12
      set_cfg(1'b0, 1'b1, 20, 6, 0, 8'h00, 8'h01);
      fire(1'b0);
      for (int k = 1; k <= 16; k++) begin
         e = '0;
         e[0] = (k == 12);
         check($sformatf("R10 retrigger k=%0d", k), {trig_out, pre_trig}, with_or(e));
         sw_trig = (k == 4);
         @(negedge clk);
      end
      sw_trig = 1'b0;

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule